// File: doc/BRIEF.md
# I2C Digital Potentiometer Register Controller

This block is the serial control front end of a 256-step digital potentiometer. It acts as an I2C target at one fixed 7-bit address. A host first sends a register pointer byte and then streams data bytes, or it reads bytes back from the pointer. The block holds a volatile wiper code, a retained preset code that stands in for the non-volatile start-up value, a mode register and a read-only identification byte. The wiper code drives the analog ladder directly through `wiper_o`.

Register 00h has two roles, and bit 7 of the mode register at 08h selects between them. With the bit clear, a write to 00h updates both the wiper and the preset, and a read of 00h returns the preset. With the bit set, a write to 00h moves only the wiper, and a read returns the wiper. A preset update models the slow storage cell. It holds `nv_busy_o` high for `NV_CYCLES` clocks. During that time the target refuses its own address, so a host can poll for completion. Within one transaction, no byte after a preset update is stored.

The SCL and SDA inputs pass through a parameterised synchronizer. All bus activity is then handled in the system clock domain. SDA is driven open-drain: `sda_oe_o` high means the line is pulled low.

Top module: `i2c_pot_top`

## Requirements
- R1: The target acknowledges only the address byte 50h (write) or 51h (read), which is the 7-bit address 28h followed by the R/W bit. Any other address byte is not acknowledged (SDA stays released in the ninth bit), and every later byte of that transaction is ignored and not acknowledged.
- R2: In a write, the byte after the address is taken as the register pointer. Each following data byte is acknowledged and stored at the pointer, and the pointer then advances by one, wrapping from FFh to 00h.
- R3: When mode bit 7 is 0, a write to 00h loads the same byte into the wiper and the preset, and a read of 00h returns the preset.
- R4: When mode bit 7 is 1, a write to 00h loads only the wiper and leaves the preset unchanged, and a read of 00h returns the wiper.
- R5: Register 01h reads as the identification byte `DEV_ID`, whose bit 7 is 1 (default B7h). A write to 01h is acknowledged and changes no register.
- R6: After reset, the preset and the wiper both hold 80h, the mode register holds 00h, `nv_busy_o` is low and SDA is released.
- R7: `wiper_o` takes a written code before the acknowledge bit of that data byte completes, while `nv_busy_o` is still high from the same write.
- R8: A preset update raises `nv_busy_o` for exactly `NV_CYCLES` clock cycles (default 2000).
- R9: After a preset update, later data bytes in the same transaction are not acknowledged and not stored, and the pointer stays at 00h.
- R10: While `nv_busy_o` is high, the target does not acknowledge its address byte in either direction.
- R11: A read returns the byte at the pointer. The pointer advances by one after each byte sent, and the next byte follows when the host acknowledges. Register 08h reads back the mode byte, and unmapped registers read 00h.
- R12: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe_o | output | 1 | Pull SDA low when high (open-drain drive) |
| wiper_o | output | 8 | Wiper code to the resistor ladder |
| nv_busy_o | output | 1 | Preset storage update in progress |

## Verification
Bus edges reach the protocol logic `SYNC_STAGES` plus one clock after they occur on the pins. SDA drive therefore changes a few clocks after each SCL fall, well inside the low phase. The bench samples acknowledge bits and read data in the middle of the SCL high phase, ten clocks after the rise. The wiper code settles one clock after the internal write strobe, which fires on the SCL fall that ends the eighth data bit. The bench reads `wiper_o` and `nv_busy_o` after that byte's acknowledge slot and again after STOP. The busy length is counted clock by clock on the falling edge and compared with `NV_CYCLES` once the flag drops.

// File: rtl/i2c_pot_pkg.sv
package i2c_pot_pkg;

   localparam int BYTE_W = 8;

   // register pointer values that carry behaviour
   localparam logic [BYTE_W-1:0] REG_WIPER = 8'h00;
   localparam logic [BYTE_W-1:0] REG_IDENT = 8'h01;
   localparam logic [BYTE_W-1:0] REG_MODE  = 8'h08;

   // mode register bit that selects the volatile-only personality of 00h
   localparam int MODE_VOL_BIT = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_REG,
      ST_WR,
      ST_RD
   } link_state_t;

endpackage

// File: rtl/i2c_pot_sync.sv
module i2c_pot_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   localparam int LINES = 2;

   logic [LINES-1:0] raw;
   logic [LINES-1:0] settled;
   logic [LINES-1:0] prev;

   assign raw = {scl_i, sda_i};

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], raw[l]};
      end
      assign settled[l] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= settled;
   end

   assign scl_s     = settled[1];
   assign sda_s     = settled[0];
   assign scl_rise  =  scl_s & ~prev[1];
   assign scl_fall  = ~scl_s &  prev[1];
   // SDA edges while SCL stays high are bus conditions
   assign start_det = scl_s & prev[1] &  prev[0] & ~sda_s;
   assign stop_det  = scl_s & prev[1] & ~prev[0] &  sda_s;

endmodule

// File: rtl/i2c_pot_link.sv
module i2c_pot_link
   import i2c_pot_pkg::*;
#(
   parameter logic [6:0] TARGET_ADDR = 7'h28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic              busy,
   input  logic              nv_sel,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] ptr_o,
   output logic              sda_oe
);

   localparam int                CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0]  LAST  = CNT_W'(BYTE_W);

   link_state_t       st;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_q;
   logic [BYTE_W-1:0] tx_q;
   logic [BYTE_W-1:0] ptr_q;
   logic              ack_ph;
   logic              rd_mode;
   logic              nv_lock;
   logic              mst_ack;

   assign ptr_o = ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         bit_cnt <= '0;
         rx_q    <= '0;
         tx_q    <= '0;
         ptr_q   <= '0;
         ack_ph  <= 1'b0;
         rd_mode <= 1'b0;
         nv_lock <= 1'b0;
         mst_ack <= 1'b0;
         sda_oe  <= 1'b0;
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (start_det) begin
            // also covers a repeated START; the pointer is kept
            st      <= ST_DEV;
            bit_cnt <= '0;
            ack_ph  <= 1'b0;
         end else if (stop_det) begin
            st      <= ST_IDLE;
            ack_ph  <= 1'b0;
            nv_lock <= 1'b0;
         end else if (scl_rise) begin
            if (st != ST_IDLE && !ack_ph) begin
               rx_q    <= {rx_q[BYTE_W-2:0], sda_s};
               bit_cnt <= bit_cnt + 1'b1;
            end else if (st == ST_RD && ack_ph) begin
               mst_ack <= ~sda_s;
            end
         end else if (scl_fall && st != ST_IDLE) begin
            if (!ack_ph && bit_cnt == LAST) begin
               // eighth bit done: open the acknowledge slot
               bit_cnt <= '0;
               case (st)
                  ST_DEV: begin
                     if (rx_q[BYTE_W-1:1] == TARGET_ADDR && !busy) begin
                        ack_ph  <= 1'b1;
                        sda_oe  <= 1'b1;
                        rd_mode <= rx_q[0];
                     end else begin
                        st     <= ST_IDLE;
                        sda_oe <= 1'b0;
                     end
                  end
                  ST_REG: begin
                     ack_ph <= 1'b1;
                     sda_oe <= 1'b1;
                     ptr_q  <= rx_q;
                  end
                  ST_WR: begin
                     ack_ph <= 1'b1;
                     if (nv_lock) begin
                        sda_oe <= 1'b0;
                     end else begin
                        sda_oe  <= 1'b1;
                        wr_stb  <= 1'b1;
                        wr_addr <= ptr_q;
                        wr_data <= rx_q;
                        if (nv_sel) nv_lock <= 1'b1;
                        else        ptr_q   <= ptr_q + 1'b1;
                     end
                  end
                  ST_RD: begin
                     ack_ph  <= 1'b1;
                     sda_oe  <= 1'b0;
                     mst_ack <= 1'b0;
                     ptr_q   <= ptr_q + 1'b1;
                  end
                  default: ;
               endcase
            end else if (ack_ph) begin
               // acknowledge slot over
               ack_ph <= 1'b0;
               case (st)
                  ST_DEV: begin
                     if (rd_mode) begin
                        st     <= ST_RD;
                        tx_q   <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                     end else begin
                        st     <= ST_REG;
                        sda_oe <= 1'b0;
                     end
                  end
                  ST_REG: begin
                     st     <= ST_WR;
                     sda_oe <= 1'b0;
                  end
                  ST_WR: sda_oe <= 1'b0;
                  ST_RD: begin
                     if (mst_ack) begin
                        tx_q   <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                     end else begin
                        st     <= ST_IDLE;
                        sda_oe <= 1'b0;
                     end
                  end
                  default: sda_oe <= 1'b0;
               endcase
            end else if (st == ST_RD) begin
               tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
               sda_oe <= ~tx_q[BYTE_W-2];
            end
         end
      end
   end

endmodule

// File: rtl/i2c_pot_nvtimer.sv
module i2c_pot_nvtimer #(
   parameter int CYCLES = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int             CW   = $clog2(CYCLES + 1);
   localparam logic [CW-1:0]  LOAD = CW'(CYCLES);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (start)          remain <= LOAD;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

endmodule

// File: rtl/i2c_pot_regs.sv
module i2c_pot_regs
   import i2c_pot_pkg::*;
#(
   parameter logic [BYTE_W-1:0] PRESET_INIT = 8'h80,
   parameter logic [BYTE_W-1:0] DEV_ID      = 8'hB7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [BYTE_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [BYTE_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   output logic              nv_sel,
   output logic              nv_start,
   output logic [BYTE_W-1:0] wiper_o,
   output logic [BYTE_W-1:0] preset_o,
   output logic [BYTE_W-1:0] mode_o
);

   logic [BYTE_W-1:0] wiper_q;
   logic [BYTE_W-1:0] preset_q;
   logic [BYTE_W-1:0] mode_q;
   logic              vol_only;
   logic              hit_wiper;
   logic              hit_mode;

   assign vol_only  = mode_q[MODE_VOL_BIT];
   assign hit_wiper = wr_stb && (wr_addr == REG_WIPER);
   assign hit_mode  = wr_stb && (wr_addr == REG_MODE);

   // the wiper starts from the preset's reset value
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preset_q <= PRESET_INIT;
         wiper_q  <= PRESET_INIT;
         mode_q   <= '0;
      end else begin
         if (hit_wiper) begin
            wiper_q <= wr_data;
            if (!vol_only) preset_q <= wr_data;
         end
         if (hit_mode) mode_q <= wr_data;
      end
   end

   assign nv_start = hit_wiper && !vol_only;
   assign nv_sel   = (rd_addr == REG_WIPER) && !vol_only;

   always_comb begin
      case (rd_addr)
         REG_WIPER: rd_data = vol_only ? wiper_q : preset_q;
         REG_IDENT: rd_data = DEV_ID;
         REG_MODE:  rd_data = mode_q;
         default:   rd_data = '0;
      endcase
   end

   assign wiper_o  = wiper_q;
   assign preset_o = preset_q;
   assign mode_o   = mode_q;

endmodule

// File: rtl/i2c_pot_top.sv
module i2c_pot_top
   import i2c_pot_pkg::*;
#(
   parameter logic [6:0]        TARGET_ADDR = 7'h28,
   parameter logic [BYTE_W-1:0] DEV_ID      = 8'hB7,
   parameter logic [BYTE_W-1:0] PRESET_INIT = 8'h80,
   parameter int                NV_CYCLES   = 2000,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic [BYTE_W-1:0] wiper_o,
   output logic              nv_busy_o
);

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (NV_CYCLES >= 1)   else $error("NV_CYCLES must be at least 1");
      assert (DEV_ID[BYTE_W-1]) else $error("DEV_ID bit 7 must be set");
   end

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              wr_stb;
   logic [BYTE_W-1:0] wr_addr;
   logic [BYTE_W-1:0] wr_data;
   logic [BYTE_W-1:0] ptr;
   logic [BYTE_W-1:0] rd_data;
   logic              nv_sel;
   logic              nv_start;
   logic [BYTE_W-1:0] preset_val;
   logic [BYTE_W-1:0] mode_val;

   i2c_pot_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_pot_link #(.TARGET_ADDR(TARGET_ADDR)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_s     (sda_s),
      .busy      (nv_busy_o),
      .nv_sel    (nv_sel),
      .rd_data   (rd_data),
      .wr_stb    (wr_stb),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .ptr_o     (ptr),
      .sda_oe    (sda_oe_o)
   );

   i2c_pot_regs #(.PRESET_INIT(PRESET_INIT), .DEV_ID(DEV_ID)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (ptr),
      .rd_data  (rd_data),
      .nv_sel   (nv_sel),
      .nv_start (nv_start),
      .wiper_o  (wiper_o),
      .preset_o (preset_val),
      .mode_o   (mode_val)
   );

   i2c_pot_nvtimer #(.CYCLES(NV_CYCLES)) u_nvt (
      .clk   (clk),
      .rst_n (rst_n),
      .start (nv_start),
      .busy  (nv_busy_o)
   );

endmodule

// File: rtl/i2c_pot_chk.sv
module i2c_pot_chk #(
   parameter int NV_CYCLES = 2000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       sda_oe,
   input logic       wr_stb,
   input logic [7:0] wr_addr,
   input logic [7:0] wr_data,
   input logic [7:0] wiper,
   input logic [7:0] preset,
   input logic [7:0] mode,
   input logic       busy
);

   int unsigned busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   // R4: the wiper moves only as the result of a write to 00h
   assert_wiper_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wiper != $past(wiper)) |-> $past(wr_stb && wr_addr == 8'h00));

   // R7: a write to 00h shows on the wiper on the next clock
   assert_wiper_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr == 8'h00) |=> (wiper == $past(wr_data)));

   // R3: the preset changes only on a write to 00h with mode bit 7 clear
   assert_preset_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (preset != $past(preset)) |-> $past(wr_stb && wr_addr == 8'h00 && !mode[7]));

   // R8: busy starts only from a preset update
   assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_stb && wr_addr == 8'h00 && !mode[7]));

   // R8: busy lasts exactly NV_CYCLES clocks
   assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run == NV_CYCLES));

   // R12: SDA drive is stable while SCL stays high
   assert_oe_scl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_oe));

endmodule

bind i2c_pot_top i2c_pot_chk #(.NV_CYCLES(NV_CYCLES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_s   (scl_s),
   .sda_oe  (sda_oe_o),
   .wr_stb  (wr_stb),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .wiper   (wiper_o),
   .preset  (preset_val),
   .mode    (mode_val),
   .busy    (nv_busy_o)
);

// File: tb/test_i2c_pot_top.sv
`timescale 1ns/1ps
module test_i2c_pot_top;

   localparam int         NV  = 2000;
   localparam int         Q   = 10;
   localparam logic [7:0] DID = 8'hB7;
   localparam logic [7:0] DW  = 8'h50;
   localparam logic [7:0] DR  = 8'h51;

   // {register, write byte, expected read, expected wiper}
   localparam logic [31:0] VEC [7] = '{
      32'h08_80_80_11,
      32'h00_3C_3C_3C,
      32'h01_00_B7_3C,
      32'h05_AA_00_3C,
      32'hFF_11_00_3C,
      32'h00_F0_F0_F0,
      32'h08_00_00_F0
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe_o;
   logic [7:0] wiper_o;
   logic       nv_busy_o;
   wire        sda_line = sda_m & ~sda_oe_o;

   int n_cmp = 0;
   int n_bad = 0;
   int busy_cycles = 0;
   int oe_glitch = 0;
   logic scl_prev = 1'b1;
   logic oe_prev = 1'b0;

   always #2.5 clk = ~clk;

   i2c_pot_top i_i2c_pot_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .sda_oe_o  (sda_oe_o),
      .wiper_o   (wiper_o),
      .nv_busy_o (nv_busy_o)
   );

   always @(negedge clk) begin
      if (rst_n && nv_busy_o) busy_cycles++;
      if (rst_n && scl_m && scl_prev && (sda_oe_o !== oe_prev)) oe_glitch++;
      scl_prev = scl_m;
      oe_prev  = sda_oe_o;
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; q();
      scl_m = 1'b1; q();
      sda_m = 1'b0; q();
      scl_m = 1'b0; q();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; q();
      scl_m = 1'b1; q();
      sda_m = 1'b1; q(); q();
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; q();
      scl_m = 1'b1; q(); q();
      scl_m = 1'b0; q();
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; q();
      scl_m = 1'b1; q();
      b = sda_line; q();
      scl_m = 1'b0; q();
   endtask

   task automatic put_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic get_byte(input logic ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(~ack);
   endtask

   task automatic xfer_write(input logic [7:0] devb, input logic [7:0] rg,
                             input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                             input int n, output logic [4:0] acks,
                             output logic [7:0] snap_w, output logic snap_b);
      logic a;
      acks = '0;
      snap_w = '0;
      snap_b = 1'b0;
      i2c_start();
      put_byte(devb, a); acks[0] = a;
      put_byte(rg, a);   acks[1] = a;
      for (int i = 0; i < n; i++) begin
         put_byte((i == 0) ? d0 : (i == 1) ? d1 : d2, a);
         acks[2+i] = a;
         if (i == 0) begin
            snap_w = wiper_o;
            snap_b = nv_busy_o;
         end
      end
      i2c_stop();
   endtask

   task automatic xfer_read(input logic setreg, input logic [7:0] rg, input int n,
                            output logic [7:0] r0, output logic [7:0] r1, output logic [7:0] r2,
                            output logic ok);
      logic a1, a2, a3;
      logic [7:0] v;
      a1 = 1'b1;
      a2 = 1'b1;
      r0 = '0; r1 = '0; r2 = '0;
      i2c_start();
      if (setreg) begin
         put_byte(DW, a1);
         put_byte(rg, a2);
         i2c_start();
      end
      put_byte(DR, a3);
      for (int i = 0; i < n; i++) begin
         get_byte(i != n - 1, v);
         if (i == 0) r0 = v;
         else if (i == 1) r1 = v;
         else r2 = v;
      end
      i2c_stop();
      ok = a1 & a2 & a3;
   endtask

   task automatic wait_idle();
      while (nv_busy_o) @(negedge clk);
      q();
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      finish_run();
   end

   initial begin
      logic [4:0] acks;
      logic [7:0] sw, r0, r1, r2;
      logic       sb, ok;

      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      q();

      // R6: reset state
      chk("R6 wiper after reset", wiper_o, 8'h80);
      chk("R6 busy after reset", {7'd0, nv_busy_o}, 8'h00);
      chk("R6 sda released", {7'd0, sda_oe_o}, 8'h00);
      xfer_read(1'b1, 8'h00, 1, r0, r1, r2, ok);
      chk("R6 R3 preset read", r0, 8'h80);
      xfer_read(1'b1, 8'h08, 1, r0, r1, r2, ok);
      chk("R6 mode read", r0, 8'h00);
      chk("R11 read acks", {7'd0, ok}, 8'h01);

      // R1: foreign address, rest of transaction ignored
      xfer_write(8'h52, 8'h00, 8'h99, 8'h00, 8'h00, 1, acks, sw, sb);
      chk("R1 foreign address acks", {3'd0, acks}, 8'h00);
      chk("R1 wiper untouched", wiper_o, 8'h80);

      // R3 R7 R8: preset update in non-volatile mode
      busy_cycles = 0;
      xfer_write(DW, 8'h00, 8'h5A, 8'h00, 8'h00, 1, acks, sw, sb);
      chk("R3 write acks", {3'd0, acks}, 8'h07);
      chk("R7 wiper at data ack", sw, 8'h5A);
      chk("R7 busy at data ack", {7'd0, sb}, 8'h01);
      // R10: target refuses its address while busy
      xfer_read(1'b0, 8'h00, 1, r0, r1, r2, ok);
      chk("R10 address refused while busy", {7'd0, ok}, 8'h00);
      chk("R10 still busy", {7'd0, nv_busy_o}, 8'h01);
      wait_idle();
      chk("R8 busy length", 8'(busy_cycles), 8'(NV));
      n_cmp++;
      if (busy_cycles != NV) begin
         n_bad++;
         $display("FAIL R8 busy cycles act=%0d exp=%0d", busy_cycles, NV);
      end
      xfer_read(1'b1, 8'h00, 1, r0, r1, r2, ok);
      chk("R3 preset readback", r0, 8'h5A);

      // R9: bytes after a preset update are refused
      xfer_write(DW, 8'h00, 8'h11, 8'h22, 8'h33, 3, acks, sw, sb);
      chk("R9 acks", {3'd0, acks}, 8'h07);
      chk("R9 wiper keeps first byte", wiper_o, 8'h11);
      wait_idle();
      xfer_read(1'b0, 8'h00, 1, r0, r1, r2, ok);
      chk("R9 pointer held at 00h", r0, 8'h11);
      chk("R9 read acked", {7'd0, ok}, 8'h01);

      // R4 R5 R11: vector table
      for (int k = 0; k < 7; k++) begin
         logic [31:0] v;
         v = VEC[k];
         xfer_write(DW, v[31:24], v[23:16], 8'h00, 8'h00, 1, acks, sw, sb);
         chk($sformatf("R5 R2 row %0d acks", k), {3'd0, acks}, 8'h07);
         xfer_read(1'b1, v[31:24], 1, r0, r1, r2, ok);
         chk($sformatf("R4 R11 row %0d read", k), r0, v[15:8]);
         chk($sformatf("R4 row %0d wiper", k), wiper_o, v[7:0]);
         wait_idle();
      end
      xfer_read(1'b1, 8'h00, 1, r0, r1, r2, ok);
      chk("R4 preset untouched by volatile writes", r0, 8'h11);

      // R2: auto-increment with wrap into 00h (non-volatile mode)
      xfer_write(DW, 8'hFE, 8'h00, 8'h00, 8'h42, 3, acks, sw, sb);
      chk("R2 wrap acks", {3'd0, acks}, 8'h1F);
      chk("R2 wrapped write to wiper", wiper_o, 8'h42);
      wait_idle();

      // R11: multi-byte read with pointer advance
      xfer_read(1'b1, 8'h00, 3, r0, r1, r2, ok);
      chk("R11 byte 0", r0, 8'h42);
      chk("R11 byte 1 ident R5", r1, DID);
      chk("R11 byte 2 unmapped", r2, 8'h00);

      // R12: no SDA drive change while SCL high
      chk("R12 oe changes with scl high", 8'(oe_glitch), 8'h00);

      // R6: reset again mid-life
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      q();
      chk("R6 wiper after second reset", wiper_o, 8'h80);
      xfer_read(1'b1, 8'h00, 1, r0, r1, r2, ok);
      chk("R6 preset after second reset", r0, 8'h80);

      finish_run();
   end

endmodule